// File: doc/BRIEF.md
# Burst-of-Two Separate-Port SRAM Model

This block is a synthesizable, cycle-level model of a synchronous SRAM that has a separate write path and read path. Every command moves a pair of words. One address port selects a word pair. The block makes the least significant bit of the word address itself: the even word of the pair goes on beat lane 0 and the odd word on beat lane 1. The two halves of a double-rate transfer are shown as two parallel lanes, so the whole model runs on one clock.

A read strobe and a write strobe may both be asserted in the same cycle. Read data leaves a fixed two-stage pipeline with a valid flag. Write data and its per-byte enables arrive one cycle after the write command and are committed at the end of that cycle. A read issued while that data is still in flight sees the merged new contents, so the two pipelines stay coherent.

Top module: `b2s_sram`

## Requirements
- R1: `cmd_addr` is the word-pair index, one bit narrower than the word address. The word with address LSB 0 goes on the `*_beat0` lane and the word with LSB 1 goes on the `*_beat1` lane. Each command moves both words.
- R2: A read strobe sampled at rising edge k puts its data on `rd_beat0`/`rd_beat1`, with `rd_valid` high, during the cycle after edge k+2. The outputs do not change at edge k or edge k+1.
- R3: `rd_valid` is high only during cycles that carry read data. In every other cycle, including reset, `rd_valid` is 0 and both read lanes are 0.
- R4: A new read may be issued every cycle. Back-to-back reads come out on consecutive cycles with no gap.
- R5: Write data and enables are taken in the cycle after the write strobe. Enable bit i covers data bits [i*BYTE_W +: BYTE_W]. A byte whose enable bit is 0 keeps its old contents. Enables present in the command cycle itself have no effect.
- R6: A read and a write issued in the same cycle are both accepted. The read returns the contents held before that write.
- R7: A read issued in the cycle that carries a write's data, to the same pair, returns the new bytes where enabled and the old bytes elsewhere.
- R8: Write data and enables presented when no write command was issued in the cycle before leave the array unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_rd | input | 1 | Read strobe |
| cmd_wr | input | 1 | Write strobe |
| cmd_addr | input | ADDR_W | Word-pair address shared by both strobes |
| wr_beat0 | input | WORD_W | Write data, even word |
| wr_beat1 | input | WORD_W | Write data, odd word |
| wr_ben0 | input | WORD_W/BYTE_W | Byte enables for the even word |
| wr_ben1 | input | WORD_W/BYTE_W | Byte enables for the odd word |
| rd_beat0 | output | WORD_W | Read data, even word |
| rd_beat1 | output | WORD_W | Read data, odd word |
| rd_valid | output | 1 | High while read data is present |

## Verification
The bench targets several ordering corner cases.

- A read issued together with a write to the same pair must return the old words. A model that forwards too eagerly would return the new ones.
- A read issued in the write's data cycle must return merged bytes. A model without forwarding would return stale words, and one that ignores the mask would clobber disabled bytes.
- Stray write data with no command in front of it must leave the array intact, and a masked write must touch only its enabled bytes.
- Three back-to-back reads must come out on three consecutive cycles, each valid exactly once and zero afterwards. This exposes a latency that is off by one or a pipeline that inserts bubbles.

// File: rtl/b2s_pkg.sv
package b2s_pkg;
   // beats per command: lane 0 = even word, lane 1 = odd word
   localparam int unsigned BEATS  = 2;
   // rising edges from command capture to read data on the ports
   localparam int unsigned RD_LAT = 2;
endpackage

// File: rtl/b2s_lane.sv
module b2s_lane #(
   parameter  int unsigned DATA_W = 18,
   parameter  int unsigned BYTE_W = 9,
   parameter  int unsigned AW     = 4,
   localparam int unsigned NB     = DATA_W / BYTE_W
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [NB-1:0]     wr_ben,
   input  logic [AW-1:0]     rd_addr,
   input  logic              fwd_hit,
   output logic [DATA_W-1:0] rd_word
);
   localparam int unsigned DEPTH = 1 << AW;

   logic [DATA_W-1:0] mem [DEPTH];

   // byte-masked commit at the end of the data cycle
   always_ff @(posedge clk) begin
      if (wr_en) begin
         for (int b = 0; b < NB; b++) begin
            if (wr_ben[b]) mem[wr_addr][b*BYTE_W +: BYTE_W] <= wr_data[b*BYTE_W +: BYTE_W];
         end
      end
   end

   // array read with bypass of the write still in flight
   always_comb begin
      rd_word = mem[rd_addr];
      if (fwd_hit) begin
         for (int b = 0; b < NB; b++) begin
            if (wr_ben[b]) rd_word[b*BYTE_W +: BYTE_W] = wr_data[b*BYTE_W +: BYTE_W];
         end
      end
   end
endmodule

// File: rtl/b2s_rdpipe.sv
module b2s_rdpipe #(
   parameter int unsigned DATA_W = 18,
   parameter int unsigned STAGES = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_w0,
   input  logic [DATA_W-1:0] in_w1,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_w0,
   output logic [DATA_W-1:0] out_w1
);
   logic              v_q  [STAGES];
   logic [DATA_W-1:0] w0_q [STAGES];
   logic [DATA_W-1:0] w1_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) begin
            v_q[s]  <= 1'b0;
            w0_q[s] <= '0;
            w1_q[s] <= '0;
         end
      end else begin
         // zero the data of empty slots so idle outputs read as zero
         v_q[0]  <= in_valid;
         w0_q[0] <= in_valid ? in_w0 : '0;
         w1_q[0] <= in_valid ? in_w1 : '0;
         for (int s = 1; s < STAGES; s++) begin
            v_q[s]  <= v_q[s-1];
            w0_q[s] <= w0_q[s-1];
            w1_q[s] <= w1_q[s-1];
         end
      end
   end

   assign out_valid = v_q[STAGES-1];
   assign out_w0    = w0_q[STAGES-1];
   assign out_w1    = w1_q[STAGES-1];
endmodule

// File: rtl/b2s_sram.sv
module b2s_sram
   import b2s_pkg::*;
#(
   parameter  int unsigned BYTE_W = 9,
   parameter  int unsigned WORD_W = 18,
   parameter  int unsigned ADDR_W = 4,
   localparam int unsigned NB     = WORD_W / BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_rd,
   input  logic              cmd_wr,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [WORD_W-1:0] wr_beat0,
   input  logic [WORD_W-1:0] wr_beat1,
   input  logic [NB-1:0]     wr_ben0,
   input  logic [NB-1:0]     wr_ben1,
   output logic [WORD_W-1:0] rd_beat0,
   output logic [WORD_W-1:0] rd_beat1,
   output logic              rd_valid
);
   localparam int unsigned PIPE_STAGES = RD_LAT + 1;

   if (BYTE_W != 8 && BYTE_W != 9) begin : g_bad_byte
      $error("b2s_sram: BYTE_W must be 8 or 9");
   end
   if (WORD_W % BYTE_W != 0 || NB == 0) begin : g_bad_word
      $error("b2s_sram: WORD_W must be a non-zero multiple of BYTE_W");
   end
   if (ADDR_W < 1 || ADDR_W > 10) begin : g_bad_addr
      $error("b2s_sram: ADDR_W out of the modelled range 1..10");
   end

   // write command captured; its data arrives next cycle
   logic              wr_pend_q;
   logic [ADDR_W-1:0] wr_addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_pend_q <= 1'b0;
         wr_addr_q <= '0;
      end else begin
         wr_pend_q <= cmd_wr;
         if (cmd_wr) wr_addr_q <= cmd_addr;
      end
   end

   logic fwd_hit;
   assign fwd_hit = wr_pend_q && (wr_addr_q == cmd_addr);

   logic [WORD_W-1:0] wbeat [BEATS];
   logic [NB-1:0]     wben  [BEATS];
   logic [WORD_W-1:0] rword [BEATS];

   assign wbeat[0] = wr_beat0;
   assign wbeat[1] = wr_beat1;
   assign wben[0]  = wr_ben0;
   assign wben[1]  = wr_ben1;

   // one bank per beat: bank l holds word {pair, l}
   for (genvar l = 0; l < BEATS; l++) begin : g_lane
      b2s_lane #(
         .DATA_W(WORD_W),
         .BYTE_W(BYTE_W),
         .AW    (ADDR_W)
      ) u_lane (
         .clk    (clk),
         .wr_en  (wr_pend_q),
         .wr_addr(wr_addr_q),
         .wr_data(wbeat[l]),
         .wr_ben (wben[l]),
         .rd_addr(cmd_addr),
         .fwd_hit(fwd_hit),
         .rd_word(rword[l])
      );
   end

   b2s_rdpipe #(
      .DATA_W(WORD_W),
      .STAGES(PIPE_STAGES)
   ) u_pipe (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (cmd_rd),
      .in_w0    (rword[0]),
      .in_w1    (rword[1]),
      .out_valid(rd_valid),
      .out_w0   (rd_beat0),
      .out_w1   (rd_beat1)
   );
endmodule

// File: rtl/b2s_sram_chk.sv
module b2s_sram_chk #(
   parameter  int unsigned BYTE_W = 9,
   parameter  int unsigned WORD_W = 18,
   parameter  int unsigned ADDR_W = 4,
   localparam int unsigned NB     = WORD_W / BYTE_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_rd,
   input logic              cmd_wr,
   input logic [ADDR_W-1:0] cmd_addr,
   input logic [WORD_W-1:0] wr_beat0,
   input logic [WORD_W-1:0] wr_beat1,
   input logic [NB-1:0]     wr_ben0,
   input logic [NB-1:0]     wr_ben1,
   input logic [WORD_W-1:0] rd_beat0,
   input logic [WORD_W-1:0] rd_beat1,
   input logic              rd_valid
);
   // edges seen since reset release, saturating
   logic [2:0] warm;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) warm <= '0;
      else if (warm != 3'd7) warm <= warm + 3'd1;
   end

   // R3
   idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_valid |-> (rd_beat0 == '0 && rd_beat1 == '0));

   // R2
   read_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (warm >= 3'd3) |-> (rd_valid == $past(cmd_rd, 3)));

   // R7
   fwd_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (warm >= 3'd4 && $past(cmd_rd, 3) && $past(cmd_wr, 4)
       && $past(cmd_addr, 4) == $past(cmd_addr, 3)
       && $past(wr_ben0, 3) == '1 && $past(wr_ben1, 3) == '1)
      |-> (rd_beat0 == $past(wr_beat0, 3) && rd_beat1 == $past(wr_beat1, 3)));

   // R4
   repeat_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (warm >= 3'd4 && $past(cmd_rd, 3) && $past(cmd_rd, 4)
       && $past(cmd_addr, 3) == $past(cmd_addr, 4) && !$past(cmd_wr, 4))
      |-> (rd_valid && rd_beat0 == $past(rd_beat0) && rd_beat1 == $past(rd_beat1)));
endmodule

bind b2s_sram b2s_sram_chk #(
   .BYTE_W(BYTE_W),
   .WORD_W(WORD_W),
   .ADDR_W(ADDR_W)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .cmd_rd  (cmd_rd),
   .cmd_wr  (cmd_wr),
   .cmd_addr(cmd_addr),
   .wr_beat0(wr_beat0),
   .wr_beat1(wr_beat1),
   .wr_ben0 (wr_ben0),
   .wr_ben1 (wr_ben1),
   .rd_beat0(rd_beat0),
   .rd_beat1(rd_beat1),
   .rd_valid(rd_valid)
);

// File: tb/b2s_sram_test.sv
`timescale 1ns/1ps
module b2s_sram_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_rd = 1'b0;
   logic        cmd_wr = 1'b0;
   logic [3:0]  cmd_addr = '0;
   logic [17:0] wr_beat0 = '0;
   logic [17:0] wr_beat1 = '0;
   logic [1:0]  wr_ben0 = '0;
   logic [1:0]  wr_ben1 = '0;
   logic [17:0] rd_beat0;
   logic [17:0] rd_beat1;
   logic        rd_valid;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   b2s_sram #(.BYTE_W(9), .WORD_W(18), .ADDR_W(4)) uut (
      .clk(clk), .rst_n(rst_n), .cmd_rd(cmd_rd), .cmd_wr(cmd_wr), .cmd_addr(cmd_addr),
      .wr_beat0(wr_beat0), .wr_beat1(wr_beat1), .wr_ben0(wr_ben0), .wr_ben1(wr_ben1),
      .rd_beat0(rd_beat0), .rd_beat1(rd_beat1), .rd_valid(rd_valid)
   );

   typedef struct packed {
      logic        wr;
      logic [3:0]  a;
      logic [17:0] d0;
      logic [17:0] d1;
      logic [1:0]  b0;
      logic [1:0]  b1;
   } vec_t;

   // write: data and enables; read: expected words
   localparam vec_t TBL [11] = '{
      '{1'b1, 4'd3,  18'h12345, 18'h0ABCD, 2'b11, 2'b11},
      '{1'b1, 4'd7,  18'h3FFFF, 18'h00001, 2'b11, 2'b11},
      '{1'b0, 4'd3,  18'h12345, 18'h0ABCD, 2'b00, 2'b00},
      '{1'b0, 4'd7,  18'h3FFFF, 18'h00001, 2'b00, 2'b00},
      '{1'b1, 4'd3,  18'h00000, 18'h3FFFF, 2'b01, 2'b10},
      '{1'b0, 4'd3,  18'h12200, 18'h3FFCD, 2'b00, 2'b00},
      '{1'b1, 4'd0,  18'h11111, 18'h22222, 2'b11, 2'b11},
      '{1'b1, 4'd0,  18'h2AAAA, 18'h15555, 2'b00, 2'b00},
      '{1'b0, 4'd0,  18'h11111, 18'h22222, 2'b00, 2'b00},
      '{1'b1, 4'd15, 18'h3C3C3, 18'h0F0F0, 2'b11, 2'b11},
      '{1'b0, 4'd15, 18'h3C3C3, 18'h0F0F0, 2'b00, 2'b00}
   };

   task automatic check(input string req, input logic [36:0] got, input logic [36:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   // valid flag plus both lanes in one compare
   task automatic check_out(input string req, input logic v, input logic [17:0] e0, input logic [17:0] e1);
      check(req, {rd_valid, rd_beat1, rd_beat0}, {v, e1, e0});
   endtask

   task automatic report;
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   task automatic do_write(input logic [3:0] a, input logic [17:0] d0, input logic [17:0] d1,
                           input logic [1:0] b0, input logic [1:0] b1);
      @(negedge clk);
      cmd_wr = 1'b1; cmd_addr = a;
      // stray enables and data in the command cycle must be ignored (R5)
      wr_beat0 = 18'h15A5A; wr_beat1 = 18'h0A5A5; wr_ben0 = 2'b11; wr_ben1 = 2'b11;
      @(negedge clk);
      cmd_wr = 1'b0;
      wr_beat0 = d0; wr_beat1 = d1; wr_ben0 = b0; wr_ben1 = b1;
      @(negedge clk);
      wr_beat0 = '0; wr_beat1 = '0; wr_ben0 = '0; wr_ben1 = '0;
   endtask

   task automatic do_read(input logic [3:0] a, input logic [17:0] e0, input logic [17:0] e1, input string tag);
      @(negedge clk);
      cmd_rd = 1'b1; cmd_addr = a;
      @(negedge clk);
      cmd_rd = 1'b0;
      check_out({tag, " R2 after capture edge"}, 1'b0, 18'h0, 18'h0);
      @(negedge clk);
      check_out({tag, " R2 one edge later"}, 1'b0, 18'h0, 18'h0);
      @(negedge clk);
      check_out({tag, " R1 R2 data"}, 1'b1, e0, e1);
      @(negedge clk);
      check_out({tag, " R3 idle after read"}, 1'b0, 18'h0, 18'h0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      report();
   end

   initial begin
      // reset state (R3)
      repeat (3) @(negedge clk);
      check_out("R3 during reset", 1'b0, 18'h0, 18'h0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check_out("R3 after reset", 1'b0, 18'h0, 18'h0);

      // table walk: R1 lanes, R5 masking, R2 timing
      for (int i = 0; i < 11; i++) begin
         if (TBL[i].wr) do_write(TBL[i].a, TBL[i].d0, TBL[i].d1, TBL[i].b0, TBL[i].b1);
         else           do_read(TBL[i].a, TBL[i].d0, TBL[i].d1, $sformatf("R5 table %0d", i));
      end

      // R4: three reads on consecutive cycles
      @(negedge clk); cmd_rd = 1'b1; cmd_addr = 4'd3;
      @(negedge clk); cmd_addr = 4'd7;
      @(negedge clk); cmd_addr = 4'd15;
      @(negedge clk); cmd_rd = 1'b0;
      check_out("R4 first of burst", 1'b1, 18'h12200, 18'h3FFCD);
      @(negedge clk);
      check_out("R4 second of burst", 1'b1, 18'h3FFFF, 18'h00001);
      @(negedge clk);
      check_out("R4 third of burst", 1'b1, 18'h3C3C3, 18'h0F0F0);
      @(negedge clk);
      check_out("R4 R3 burst end", 1'b0, 18'h0, 18'h0);

      // R6: read and write together, same pair
      @(negedge clk); cmd_rd = 1'b1; cmd_wr = 1'b1; cmd_addr = 4'd7;
      @(negedge clk); cmd_rd = 1'b0; cmd_wr = 1'b0;
      wr_beat0 = 18'h05050; wr_beat1 = 18'h0A0A0; wr_ben0 = 2'b11; wr_ben1 = 2'b11;
      @(negedge clk); wr_beat0 = '0; wr_beat1 = '0; wr_ben0 = '0; wr_ben1 = '0;
      @(negedge clk);
      check_out("R6 same-cycle read sees old", 1'b1, 18'h3FFFF, 18'h00001);
      do_read(4'd7, 18'h05050, 18'h0A0A0, "R6 write landed");

      // R7: read in the write's data cycle, masked even lane
      @(negedge clk); cmd_wr = 1'b1; cmd_addr = 4'd3;
      @(negedge clk); cmd_wr = 1'b0; cmd_rd = 1'b1;
      wr_beat0 = 18'h3FFFF; wr_beat1 = 18'h00000; wr_ben0 = 2'b01; wr_ben1 = 2'b11;
      @(negedge clk); cmd_rd = 1'b0;
      wr_beat0 = '0; wr_beat1 = '0; wr_ben0 = '0; wr_ben1 = '0;
      @(negedge clk);
      @(negedge clk);
      check_out("R7 forwarded merge", 1'b1, 18'h123FF, 18'h00000);
      do_read(4'd3, 18'h123FF, 18'h00000, "R7 committed");

      // R8: data and enables with no write command
      @(negedge clk); cmd_addr = 4'd15;
      wr_beat0 = 18'h00000; wr_beat1 = 18'h3FFFF; wr_ben0 = 2'b11; wr_ben1 = 2'b11;
      @(negedge clk);
      @(negedge clk); wr_beat0 = '0; wr_beat1 = '0; wr_ben0 = '0; wr_ben1 = '0;
      do_read(4'd15, 18'h3C3C3, 18'h0F0F0, "R8 stray data ignored");

      report();
   end
endmodule